// File: doc/BRIEF.md
# Interrupting Event Status Word

This block holds the 16-bit status word that a host polls or reads after an interrupt in a signalling processor. Single-cycle event strobes from the tone decoders, the FFSK data path and the programming handshake latch sticky flags. The block compares each auxiliary ADC sample against a high and a low threshold and keeps a history of which threshold was crossed. A per-bit mask word decides which events raise the summary IRQ bit. A global enable in the mask word then decides whether that summary drives the active-low interrupt pin.

The host reads the word with a read strobe. In that cycle the read returns the current contents, and the clear-on-read side effect takes hold at the closing clock edge. The programming flag is the one exception: only a programming-register write strobe clears it. A power-enable input gates the whole block. While it is low, the block reads as zero, holds its state, ignores events and leaves the pin released.

Top module: `sig_status_unit`

## Requirements
- R1: After reset the status word and the mask word are both zero, and irqN is 1.
- R2: Events latch sticky flags: tone event bit 13, four-tone-set event bit 12, CTCSS event bit 11, DCS event bit 10, FFSK transfer bit 6, 2400 b/s rate bit 4, 1200 b/s rate bit 3. A read returns the word as it stands and clears bits 15 down to 1 at the end of the read cycle.
- R3: The programming-request event sets bit 0. A status read leaves bit 0 untouched. Only progWrStb clears it.
- R4: An event that arrives in the same cycle as a clearing read or a programming write wins, and its bit is 1 afterwards.
- R5: A valid ADC sample strictly above adcHighThr sets bit 9, and one strictly below adcLowThr sets bit 8. Both bits are sticky and can be 1 together.
- R6: In receive mode (txMode 0), blockEndEvt sets bits 7 and 6 and loads bit 5 with crcErr in the same cycle. In transmit mode blockEndEvt has no effect.
- R7: Bit 15 becomes 1 when an event sets status bit i while mask bit i is 1. For bit 5, this happens when it is loaded with 1. Bit 15 then stays 1 until a read.
- R8: irqN is 0 exactly when pwrEn is 1, status bit 15 is 1 and mask bit 15 is 1.
- R9: Bits 14, 2 and 1 always read as 0.
- R10: In transmit mode the tone, CTCSS and DCS events are ignored. The four-tone-set event sets bit 12 in either mode.
- R11: While pwrEn is 0, statRdData is 0 and irqN is 1. Events, reads and programming writes leave the stored state unchanged.
- R12: maskWrStb loads maskWrData into the mask word at the clock edge, whatever the value of pwrEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrEn | input | 1 | Power enable; status valid only when 1 |
| txMode | input | 1 | 1 = transmit, 0 = receive |
| statRdStb | input | 1 | Host read of the status word (clear-on-read) |
| progWrStb | input | 1 | Host write of the programming register |
| maskWrStb | input | 1 | Mask word write strobe |
| maskWrData | input | 16 | Mask word data; bit 15 is the global pin enable |
| toneEvt | input | 1 | In-band tone state change |
| fourToneEvt | input | 1 | Four-tone set detected or sent |
| ctcssEvt | input | 1 | CTCSS state change |
| dcsEvt | input | 1 | DCS state change |
| ffskXferEvt | input | 1 | FFSK data transfer required |
| blockEndEvt | input | 1 | End of received FFSK block |
| crcErr | input | 1 | CRC result of the block ending now |
| rate2400Evt | input | 1 | 2400 b/s data received |
| rate1200Evt | input | 1 | 1200 b/s data received |
| progReqEvt | input | 1 | Programming flag set request |
| adcValid | input | 1 | New ADC sample present |
| adcSample | input | ADC_W | ADC sample value |
| adcHighThr | input | ADC_W | High threshold |
| adcLowThr | input | ADC_W | Low threshold |
| statRdData | output | 16 | Status word (zero when powered down) |
| irqN | output | 1 | Active-low interrupt |

## Verification
The assertions assume that every strobe and event input is synchronous to clk and stable around the rising edge. They also assume that pwrEn and txMode change only between edges. The bench drives all inputs on the falling edge and compares outputs just before it drives the next set of values. The random stimulus covers events that coincide with reads and programming writes, power-down periods, mode changes in the middle of a run, and thresholds in any order, including a low threshold above the high one. This puts both ADC history bits under test together.

// File: rtl/sig_status_pkg.sv
package sig_status_pkg;
  localparam int STAT_W    = 16;
  localparam int BIT_IRQ   = 15;
  localparam int BIT_TONE  = 13;
  localparam int BIT_QUAD  = 12;
  localparam int BIT_CTCSS = 11;
  localparam int BIT_DCS   = 10;
  localparam int BIT_ADCHI = 9;
  localparam int BIT_ADCLO = 8;
  localparam int BIT_EOB   = 7;
  localparam int BIT_XFER  = 6;
  localparam int BIT_CRC   = 5;
  localparam int BIT_R2400 = 4;
  localparam int BIT_R1200 = 3;
  localparam int BIT_PROG  = 0;
  localparam logic [STAT_W-1:0] RSVD_MASK = 16'h4006;

  typedef struct packed {
    logic [STAT_W-1:0] setVec;  // bits set by events this cycle
    logic              rdClr;   // clear bits 15..1
    logic              progClr; // clear bit 0
    logic              crcLoad; // load CRC bit
    logic              crcVal;  // value to load
  } statStb_t;
endpackage

// File: rtl/sig_status_ctrl.sv
module sig_status_ctrl
  import sig_status_pkg::*;
#(
  parameter int ADC_W = 8
) (
  input  logic             pwrEn,
  input  logic             txMode,
  input  logic             statRdStb,
  input  logic             progWrStb,
  input  logic             toneEvt,
  input  logic             fourToneEvt,
  input  logic             ctcssEvt,
  input  logic             dcsEvt,
  input  logic             ffskXferEvt,
  input  logic             blockEndEvt,
  input  logic             crcErr,
  input  logic             rate2400Evt,
  input  logic             rate1200Evt,
  input  logic             progReqEvt,
  input  logic             adcValid,
  input  logic [ADC_W-1:0] adcSample,
  input  logic [ADC_W-1:0] adcHighThr,
  input  logic [ADC_W-1:0] adcLowThr,
  output statStb_t         stb
);
  logic rxBlockEnd;
  logic [STAT_W-1:0] rawSet;

  assign rxBlockEnd = blockEndEvt && !txMode;

  always_comb begin
    rawSet = '0;
    rawSet[BIT_TONE]  = toneEvt  && !txMode;
    rawSet[BIT_CTCSS] = ctcssEvt && !txMode;
    rawSet[BIT_DCS]   = dcsEvt   && !txMode;
    rawSet[BIT_QUAD]  = fourToneEvt;
    rawSet[BIT_ADCHI] = adcValid && (adcSample > adcHighThr);
    rawSet[BIT_ADCLO] = adcValid && (adcSample < adcLowThr);
    rawSet[BIT_EOB]   = rxBlockEnd;
    rawSet[BIT_XFER]  = ffskXferEvt || rxBlockEnd;
    rawSet[BIT_R2400] = rate2400Evt;
    rawSet[BIT_R1200] = rate1200Evt;
    rawSet[BIT_PROG]  = progReqEvt;
  end

  always_comb begin
    stb.setVec  = pwrEn ? (rawSet & ~RSVD_MASK) : '0;
    stb.rdClr   = pwrEn && statRdStb;
    stb.progClr = pwrEn && progWrStb;
    stb.crcLoad = pwrEn && rxBlockEnd;
    stb.crcVal  = crcErr;
  end
endmodule

// File: rtl/sig_status_dp.sv
module sig_status_dp
  import sig_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrEn,
  input  logic              maskWrStb,
  input  logic [STAT_W-1:0] maskWrData,
  input  statStb_t          stb,
  output logic [STAT_W-1:0] statRdData,
  output logic              irqN
);
  logic [STAT_W-1:0] statReg, statNxt, maskReg;
  logic irqTrig;

  always_comb begin
    irqTrig = (|(stb.setVec & maskReg)) ||
              (stb.crcLoad && stb.crcVal && maskReg[BIT_CRC]);
    statNxt = statReg;
    if (stb.rdClr)   statNxt[STAT_W-1:1] = '0;
    if (stb.progClr) statNxt[BIT_PROG] = 1'b0;
    statNxt = statNxt | stb.setVec;
    if (stb.crcLoad) statNxt[BIT_CRC] = stb.crcVal;
    if (irqTrig)     statNxt[BIT_IRQ] = 1'b1;
    statNxt = statNxt & ~RSVD_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statReg <= '0;
      maskReg <= '0;
    end else begin
      statReg <= statNxt;
      if (maskWrStb) maskReg <= maskWrData;
    end
  end

  assign statRdData = pwrEn ? statReg : '0;
  assign irqN = !(pwrEn && statReg[BIT_IRQ] && maskReg[BIT_IRQ]);

  // R3
  prog_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdClr && !stb.progClr && statReg[BIT_PROG]) |=> statReg[BIT_PROG]);

  // R2
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdClr && stb.setVec == '0 && !stb.crcLoad) |=> statReg[STAT_W-1:1] == '0);

  // R11
  pwr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pwrEn |=> $stable(statReg));

  // R6
  blk_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.setVec[BIT_EOB] |=> (statReg[BIT_EOB] && statReg[BIT_XFER]));

  // R12
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    maskWrStb |=> maskReg == $past(maskWrData));

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statReg[BIT_IRQ]) |-> $past(irqTrig));
endmodule

// File: rtl/sig_status_unit.sv
module sig_status_unit
  import sig_status_pkg::*;
#(
  parameter int ADC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwrEn,
  input  logic             txMode,
  input  logic             statRdStb,
  input  logic             progWrStb,
  input  logic             maskWrStb,
  input  logic [15:0]      maskWrData,
  input  logic             toneEvt,
  input  logic             fourToneEvt,
  input  logic             ctcssEvt,
  input  logic             dcsEvt,
  input  logic             ffskXferEvt,
  input  logic             blockEndEvt,
  input  logic             crcErr,
  input  logic             rate2400Evt,
  input  logic             rate1200Evt,
  input  logic             progReqEvt,
  input  logic             adcValid,
  input  logic [ADC_W-1:0] adcSample,
  input  logic [ADC_W-1:0] adcHighThr,
  input  logic [ADC_W-1:0] adcLowThr,
  output logic [15:0]      statRdData,
  output logic             irqN
);
  statStb_t stb;

  sig_status_ctrl #(.ADC_W(ADC_W)) u_ctrl (
    .pwrEn(pwrEn), .txMode(txMode), .statRdStb(statRdStb), .progWrStb(progWrStb),
    .toneEvt(toneEvt), .fourToneEvt(fourToneEvt), .ctcssEvt(ctcssEvt), .dcsEvt(dcsEvt),
    .ffskXferEvt(ffskXferEvt), .blockEndEvt(blockEndEvt), .crcErr(crcErr),
    .rate2400Evt(rate2400Evt), .rate1200Evt(rate1200Evt), .progReqEvt(progReqEvt),
    .adcValid(adcValid), .adcSample(adcSample), .adcHighThr(adcHighThr),
    .adcLowThr(adcLowThr), .stb(stb)
  );

  sig_status_dp u_dp (
    .clk(clk), .rstN(rstN), .pwrEn(pwrEn), .maskWrStb(maskWrStb),
    .maskWrData(maskWrData), .stb(stb), .statRdData(statRdData), .irqN(irqN)
  );
endmodule

// File: tb/sig_status_unit_bench.sv
`timescale 1ns/1ps
module sig_status_unit_bench;
  logic clk = 0, rstN = 0;
  logic pwrEn = 0, txMode = 0, statRdStb = 0, progWrStb = 0, maskWrStb = 0;
  logic [15:0] maskWrData = '0;
  logic toneEvt = 0, fourToneEvt = 0, ctcssEvt = 0, dcsEvt = 0, ffskXferEvt = 0;
  logic blockEndEvt = 0, crcErr = 0, rate2400Evt = 0, rate1200Evt = 0, progReqEvt = 0;
  logic adcValid = 0;
  logic [7:0] adcSample = '0, adcHighThr = '0, adcLowThr = '0;
  logic [15:0] statRdData;
  logic irqN;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] mStat = '0, mMask = '0;

  always #10 clk = ~clk;

  sig_status_unit u_sig_status_unit (.*);

  // behavioural reference model
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mStat = '0; mMask = '0;
    end else begin
      bit trig;
      logic [15:0] s;
      s = mStat; trig = 0;
      if (pwrEn) begin
        if (statRdStb) s = s & 16'h0001;
        if (progWrStb) s[0] = 0;
        if (toneEvt && !txMode)  begin s[13] = 1; trig |= mMask[13]; end
        if (fourToneEvt)         begin s[12] = 1; trig |= mMask[12]; end
        if (ctcssEvt && !txMode) begin s[11] = 1; trig |= mMask[11]; end
        if (dcsEvt && !txMode)   begin s[10] = 1; trig |= mMask[10]; end
        if (adcValid && adcSample > adcHighThr) begin s[9] = 1; trig |= mMask[9]; end
        if (adcValid && adcSample < adcLowThr)  begin s[8] = 1; trig |= mMask[8]; end
        if (ffskXferEvt) begin s[6] = 1; trig |= mMask[6]; end
        if (blockEndEvt && !txMode) begin
          s[7] = 1; s[6] = 1; s[5] = crcErr;
          trig |= mMask[7] | mMask[6] | (crcErr & mMask[5]);
        end
        if (rate2400Evt) begin s[4] = 1; trig |= mMask[4]; end
        if (rate1200Evt) begin s[3] = 1; trig |= mMask[3]; end
        if (progReqEvt)  begin s[0] = 1; trig |= mMask[0]; end
        if (trig) s[15] = 1;
        mStat = s;
      end
      if (maskWrStb) mMask = maskWrData;
    end
  end

  function automatic string reqOf(int b);
    case (b)
      15: return "R7";
      14, 2, 1: return "R9";
      13, 11, 10: return "R10";
      9, 8: return "R5";
      7, 5: return "R6";
      0: return "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [15:0] expRd;
    bit bad;
    expRd = pwrEn ? mStat : 16'h0;
    checks++;
    bad = 0;
    for (int b = 0; b < 16; b++)
      if (statRdData[b] !== expRd[b]) begin
        bad = 1;
        $display("FAIL %s bit%0d actual=%h expected=%h t=%0t", reqOf(b), b,
                 statRdData, expRd, $time);
      end
    if (bad) errors++;
    // R8
    chk("R8", irqN, !(pwrEn && mStat[15] && mMask[15]));
  endtask

  task automatic cyc();
    @(negedge clk);
    compareAll();
    {statRdStb, progWrStb, maskWrStb, toneEvt, fourToneEvt, ctcssEvt, dcsEvt} = '0;
    {ffskXferEvt, blockEndEvt, crcErr, rate2400Evt, rate1200Evt, progReqEvt, adcValid} = '0;
  endtask

  task automatic randomInputs();
    pwrEn      = ($urandom_range(0, 9) != 0);
    if ($urandom_range(0, 40) == 0) txMode = ~txMode;
    statRdStb  = ($urandom_range(0, 5) == 0);
    progWrStb  = ($urandom_range(0, 9) == 0);
    maskWrStb  = ($urandom_range(0, 20) == 0);
    maskWrData = 16'($urandom);
    toneEvt     = ($urandom_range(0, 12) == 0);
    fourToneEvt = ($urandom_range(0, 12) == 0);
    ctcssEvt    = ($urandom_range(0, 12) == 0);
    dcsEvt      = ($urandom_range(0, 12) == 0);
    ffskXferEvt = ($urandom_range(0, 12) == 0);
    blockEndEvt = ($urandom_range(0, 12) == 0);
    crcErr      = $urandom_range(0, 1);
    rate2400Evt = ($urandom_range(0, 12) == 0);
    rate1200Evt = ($urandom_range(0, 12) == 0);
    progReqEvt  = ($urandom_range(0, 15) == 0);
    adcValid    = ($urandom_range(0, 3) == 0);
    adcSample   = 8'($urandom);
    adcHighThr  = 8'($urandom_range(100, 255));
    adcLowThr   = 8'($urandom_range(0, 180));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    pwrEn = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1", statRdData, 16'h0);
    chk("R1", irqN, 1'b1);
    rstN = 1;
    cyc();
    // R12: mask all on
    maskWrStb = 1; maskWrData = 16'hFFFF; cyc();
    // R4: tone event together with a clearing read
    toneEvt = 1; statRdStb = 1; cyc();
    cyc();
    chk("R4", statRdData[13], 1'b1);
    chk("R8", irqN, 1'b0);
    // R3: programming flag survives a read, a write clears it
    progReqEvt = 1; cyc();
    statRdStb = 1; cyc();
    chk("R3", statRdData[0], 1'b1);
    progWrStb = 1; cyc();
    chk("R3", statRdData[0], 1'b0);
    // R5: both ADC history bits
    adcHighThr = 8'd200; adcLowThr = 8'd50;
    adcValid = 1; adcSample = 8'd220; cyc();
    adcValid = 1; adcSample = 8'd10; cyc();
    chk("R5", statRdData[9:8], 2'b11);
    // R10: transmit ignores tone events but not four-tone
    statRdStb = 1; cyc();
    txMode = 1; toneEvt = 1; dcsEvt = 1; fourToneEvt = 1; cyc();
    chk("R10", statRdData[13:10], 4'b0100);
    txMode = 0;
    // R6: block end loads CRC
    blockEndEvt = 1; crcErr = 1; cyc();
    chk("R6", statRdData[7:5], 3'b111);
    // R11: power down hides everything
    pwrEn = 0; cyc();
    chk("R11", statRdData, 16'h0);
    chk("R11", irqN, 1'b1);
    statRdStb = 1; toneEvt = 1; cyc();
    pwrEn = 1; cyc();
    chk("R11", statRdData[7:5], 3'b111);
    // R9 and random mix against the model
    for (int i = 0; i < 6000; i++) begin
      randomInputs();
      cyc();
      chk("R9", statRdData & 16'h4006, 16'h0);
    end
    finishRun();
  end
endmodule